// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Sequencer

This block is the digital half of a dual-ramp integrating converter. It steers the external analog switches, counts clock cycles and reports the conversion code. The integrator, the comparator and the offset-hold capacitor sit outside the block. While no conversion is running, the integrator input is grounded and the offset-nulling loop is closed.

A start request opens the loop and steers the input voltage into the integrator for a fixed window of 2^N clocks. That window ends when the N-bit counter wraps. The block then switches the integrator to the opposite-polarity reference and counts again until the comparator reports that the integrator has returned to its threshold. The count reached at that point is the code, and it is proportional to the average input over the window. The comparator reaches the counting logic through a two-stage synchronizer.

A run in which the comparator never fires ends at the largest count. The code is then pinned at all-ones and an overrange flag is raised.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, and whenever no conversion is running, `sw1_sel_o` is 2'b00 (ground), `sw2_close_o` is 1, `busy_o` is 0 and `count_o` is 0. Reset clears `result_o` and `overrange_o` to 0.
- R2: A `start_i` sampled high while idle causes the following changes one clock later: `busy_o` goes to 1, `sw2_close_o` goes to 0, `sw1_sel_o` goes to 2'b01 (input) and `count_o` goes to 0. The count then rises by one per clock.
- R3: The input phase lasts exactly 2^N clocks. In the clock after `count_o` reaches all-ones, `sw1_sel_o` is 2'b10 (reference) and `count_o` is 0.
- R4: In the reference phase the count rises by one per clock. `cmp_i` passes through two flip-flops before it is used. If `cmp_i` rises while `count_o` shows K, the code stored is K+2.
- R5: `eoc_o` is a single-clock pulse. It is high in the first clock after the reference phase ends, and in that clock the block is already idle with the R1 switch settings and the new `result_o` visible.
- R6: If `count_o` reaches all-ones in the reference phase and the synchronized comparator is low, `result_o` becomes all-ones and `overrange_o` becomes 1. A comparator seen at that same count gives all-ones with `overrange_o` at 0.
- R7: `cmp_i` has no effect outside the reference phase. It neither starts nor shortens a conversion.
- R8: `start_i` has no effect while `busy_o` is 1.
- R9: `result_o` and `overrange_o` keep their values until the next `eoc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured when idle |
| cmp_i | input | 1 | Asynchronous comparator output, high when integrator is back at threshold |
| sw1_sel_o | output | 2 | Integrator source: 00 ground, 01 input, 10 reference |
| sw2_close_o | output | 1 | Closes the offset-nulling loop |
| count_o | output | N | Live cycle counter |
| result_o | output | N | Last conversion code |
| eoc_o | output | 1 | End-of-conversion pulse |
| busy_o | output | 1 | Conversion in progress |
| overrange_o | output | 1 | Last conversion saturated |

## Verification
On every clock, the assertions check the following:
- the start response and the step-by-one counting of the input phase;
- the wrap into the reference phase at the all-ones count;
- that `eoc_o` is one clock wide, and that the block is idle and loop-closed whenever `eoc_o` is high;
- that an overrange flag always comes with an all-ones code.

Other behaviour shows only in the bench scenarios, where a comparator model raises `cmp_i` at a chosen count and a scoreboard compares each code. These scenarios cover the exact K+2 code latency, the boundary between saturation and a legal all-ones code, comparator activity that is ignored while idle or integrating, and codes that are held between conversions.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SEL_GND = 2'b00,
    SEL_VIN = 2'b01,
    SEL_REF = 2'b10
  } src_sel_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1; // wraps at 2^W: ends integrate
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [1:0]       sw1_sel_o,
  output logic             sw2_close_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] result_o,
  output logic             eoc_o,
  output logic             busy_o,
  output logic             overrange_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e           ph_q, ph_d;
  logic             cmp_s;
  logic             cnt_clr, cnt_inc, cnt_max;
  logic [CNT_W-1:0] cnt;
  logic             done, sat;
  logic [CNT_W-1:0] res_q;
  logic             ovr_q, eoc_q;

  dsadc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsadc_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .cnt_o   (cnt),
    .at_max_o(cnt_max)
  );

  // comparator only qualifies in the deintegrate phase
  assign sat  = (ph_q == PH_DEINT) && !cmp_s && cnt_max;
  assign done = (ph_q == PH_DEINT) && (cmp_s || cnt_max);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start_i) ph_d = PH_INTEG;
      PH_INTEG: if (cnt_max) ph_d = PH_DEINT;
      PH_DEINT: if (done)    ph_d = PH_IDLE;
      default:               ph_d = PH_IDLE;
    endcase
  end

  assign cnt_inc = (ph_q == PH_INTEG) || (ph_q == PH_DEINT);
  assign cnt_clr = (ph_q == PH_IDLE) || done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      res_q <= '0;
      ovr_q <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      eoc_q <= done;
      if (done) begin
        res_q <= sat ? CNT_MAX : cnt;
        ovr_q <= sat;
      end
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_INTEG: sw1_sel_o = SEL_VIN;
      PH_DEINT: sw1_sel_o = SEL_REF;
      default:  sw1_sel_o = SEL_GND;
    endcase
  end

  assign sw2_close_o = (ph_q == PH_IDLE);
  assign busy_o      = (ph_q != PH_IDLE);
  assign count_o     = cnt;
  assign result_o    = res_q;
  assign overrange_o = ovr_q;
  assign eoc_o       = eoc_q;

  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !sw2_close_o && sw1_sel_o == 2'b01 && count_o == '0));
  // R3
  integ_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw1_sel_o == 2'b01 && count_o == CNT_MAX) |=> (sw1_sel_o == 2'b10 && count_o == '0));
  // R3
  integ_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw1_sel_o == 2'b01 && count_o != CNT_MAX) |=> (sw1_sel_o == 2'b01));
  // R5
  eoc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (!busy_o && sw2_close_o && sw1_sel_o == 2'b00));
  // R5
  eoc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);
  // R6
  ovr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrange_o |-> (result_o == CNT_MAX));
  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |=> (eoc_o || $stable(result_o)));
endmodule

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  typedef struct {
    int    res;
    bit    ovr;
    string tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         cmp_i = 1'b0;
  logic [1:0]   sw1_sel_o;
  logic         sw2_close_o;
  logic [W-1:0] count_o;
  logic [W-1:0] result_o;
  logic         eoc_o;
  logic         busy_o;
  logic         overrange_o;

  int   checks = 0;
  int   errors = 0;
  bit   reported = 1'b0;
  exp_t sb_q[$];
  int   last_res = 0;

  always #5 clk_i = ~clk_i;

  dual_slope_seq #(.CNT_W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .sw1_sel_o(sw1_sel_o), .sw2_close_o(sw2_close_o), .count_o(count_o),
    .result_o(result_o), .eoc_o(eoc_o), .busy_o(busy_o), .overrange_o(overrange_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pop expected code on each end-of-conversion
  always @(negedge clk_i) begin
    if (rst_ni && eoc_o) begin
      if (sb_q.size() == 0) chk(1'b0, "R5 unexpected eoc", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(int'(result_o) == e.res, {e.tag, " result"}, int'(result_o), e.res);
        chk(overrange_o == e.ovr, {e.tag, " overrange"}, int'(overrange_o), int'(e.ovr));
        chk(!busy_o && sw2_close_o && sw1_sel_o == 2'b00, "R5 idle at eoc",
            int'(sw1_sel_o), 0);
      end
    end
  end

  // k < 0: comparator never fires
  task automatic convert(input int k, input bit noise, input bit poke_start,
                         input int exp_res, input bit exp_ovr, input string tag);
    int integ_len = 0;
    exp_t e;
    e.res = exp_res; e.ovr = exp_ovr; e.tag = tag;
    chk(int'(result_o) == last_res, "R9 result held while idle", int'(result_o), last_res);
    sb_q.push_back(e);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o && !sw2_close_o && sw1_sel_o == 2'b01 && count_o == '0,
        "R2 start response", int'(count_o), 0);
    while (sw1_sel_o == 2'b01) begin
      integ_len++;
      start_i = poke_start && (count_o == 8'd5); // R8
      if (noise) cmp_i = (int'(count_o) < MAX - 4); // R7
      if (integ_len == 20)
        chk(int'(result_o) == last_res, "R9 result held while busy", int'(result_o), last_res);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    cmp_i = 1'b0;
    chk(integ_len == MAX + 1, "R3 integrate length", integ_len, MAX + 1);
    chk(sw1_sel_o == 2'b10 && count_o == '0, "R3 deintegrate entry", int'(count_o), 0);
    while (busy_o) begin
      if (k >= 0 && int'(count_o) == k) cmp_i = 1'b1; // R4
      @(negedge clk_i);
    end
    chk(eoc_o == 1'b1, "R5 eoc at idle return", int'(eoc_o), 1);
    cmp_i = 1'b0;
    @(negedge clk_i);
    chk(eoc_o == 1'b0, "R5 eoc single pulse", int'(eoc_o), 0);
    chk(!busy_o && count_o == '0, "R1 idle after conversion", int'(count_o), 0);
    last_res = exp_res;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sw1_sel_o == 2'b00 && sw2_close_o && !busy_o && count_o == '0 && !eoc_o,
        "R1 reset state", int'(sw1_sel_o), 0);
    chk(result_o == '0 && !overrange_o, "R1 reset result", int'(result_o), 0);

    // R7: comparator activity while idle
    cmp_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      chk(!busy_o && !eoc_o && count_o == '0, "R7 cmp ignored idle", int'(busy_o), 0);
    end
    cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);

    convert(10,  1'b0, 1'b1, 12,  1'b0, "R4 R8 mid code");
    convert(0,   1'b0, 1'b0, 2,   1'b0, "R4 low code");
    convert(100, 1'b1, 1'b0, 102, 1'b0, "R7 cmp during integrate");
    convert(253, 1'b0, 1'b0, MAX, 1'b0, "R6 full code no ovr");
    convert(254, 1'b0, 1'b0, MAX, 1'b1, "R6 late cmp saturates");
    convert(-1,  1'b0, 1'b0, MAX, 1'b1, "R6 no cmp saturates");
    repeat (5) @(negedge clk_i);
    chk(overrange_o && int'(result_o) == MAX, "R9 overrange held", int'(overrange_o), 1);
    convert(37,  1'b0, 1'b0, 39,  1'b0, "R9 flag cleared by next");

    chk(sb_q.size() == 0, "R5 all conversions ended", sb_q.size(), 0);
    report();
  end
endmodule